// File: doc/BRIEF.md
# DRAM Strobe Pulse Timer

This block times the row and column strobes for a single DRAM access. A requester pulses a start input with three qualifiers: the access direction, a 3-bit speed code and an alignment mode. The block then drives an active-low row strobe and an active-low column strobe. Each strobe stays low for a number of reference-clock cycles that comes from a built-in width table. The table is indexed by speed, direction and alignment.

Accesses from the processor use the reference-aligned widths and start on the next clock edge. Accesses from an external bus master doing DMA use the longer graphics-aligned widths. Those accesses may only open the row strobe on the last of the three graphics-clock phases, which is flagged by `sync_t2_i`. Until that phase arrives the block waits with busy high. The column strobe fills the tail of the row window, so both strobes release on the same edge. A one-cycle done pulse then marks the end of the access.

Top module: `dram_strobe_timer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, ras_no and cas_no are 1, busy_o is 0 and done_o is 0.
- R2: With align_gclk_i=0 and is_write_i=0, ras_no is low for 10, 11, 13 and 16 cycles and cas_no is low for 4, 5, 6 and 7 cycles, for speed_sel_i = 000, 001, 010 and 011 respectively.
- R3: With align_gclk_i=0 and is_write_i=1, ras_no is low for 9, 9, 11 and 14 cycles and cas_no is low for 3, 3, 4 and 5 cycles, for codes 000 to 011 respectively.
- R4: With align_gclk_i=1, the read widths are RAS 12/12/15/18 and CAS 6/6/6/9, and the write widths are RAS 9/9/12/15 and CAS 3/3/6/6, for codes 000 to 011 respectively.
- R5: Codes 100, 101, 110 and 111 all give the widths of code 011.
- R6: cas_no is low only while ras_no is low. Its low cycles are the last ones of the row window, and it rises on the same edge as ras_no.
- R7: When align_gclk_i=1, ras_no falls only on an edge at which sync_t2_i is high. Before that edge, busy_o is high and ras_no stays high.
- R8: When align_gclk_i=0, ras_no falls on the edge that samples start_i high, whatever the level of sync_t2_i.
- R9: speed_sel_i, is_write_i and align_gclk_i are sampled only on the edge that accepts start_i. Changing them later does not alter the access in progress.
- R10: done_o is high for exactly one cycle: the first cycle in which ras_no is high again. busy_o is low in that cycle.
- R11: start_i is ignored while busy_o is high. It neither lengthens the current access nor starts another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an access; accepted when idle |
| is_write_i | input | 1 | 1 selects the write widths, 0 the read widths |
| align_gclk_i | input | 1 | 1 selects graphics-aligned widths and waiting for sync_t2_i |
| speed_sel_i | input | 3 | Speed code that selects the table row |
| sync_t2_i | input | 1 | High during the last graphics-clock phase |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| busy_o | output | 1 | Access waiting or in progress |
| done_o | output | 1 | One-cycle pulse after the strobes release |

## Verification
The bench measures every width in the table, for both directions and both alignments. An off-by-one in the window counter would show up as one extra or one missing strobe cycle. A fault in the fold of the upper speed codes would give the widths of a slower row. For aligned accesses, sync_t2_i is held low for a while first; a design that ignored the phase would open the row strobe early and with busy never raised. The qualifiers are changed right after start is accepted, and a second start is pulsed in the middle of an access. A design that read its inputs live would then change the widths partway through, and one that did not block start while busy would run a second access.

// File: rtl/dst_pkg.sv
package dst_pkg;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_RAS  = 2'd2
  } st_e;

  typedef struct packed {
    logic [CNT_W-1:0] ras;
    logic [CNT_W-1:0] cas;
  } width_t;
endpackage

// File: rtl/dst_width_lut.sv
module dst_width_lut
  import dst_pkg::*;
(
  input  logic [2:0] speed_sel_i,
  input  logic       is_write_i,
  input  logic       align_gclk_i,
  output width_t     width_o
);
  localparam int ROWS = 4;
  localparam int ROW_W = $clog2(ROWS);

  logic [ROW_W-1:0] row;
  // every code at or above 100 folds onto the fastest defined row
  assign row = speed_sel_i[2] ? ROW_W'(ROWS - 1) : speed_sel_i[ROW_W-1:0];

  always_comb begin
    width_o = '0;
    unique case ({align_gclk_i, is_write_i, row})
      4'b0_0_00: width_o = '{ras: CNT_W'(10), cas: CNT_W'(4)};
      4'b0_0_01: width_o = '{ras: CNT_W'(11), cas: CNT_W'(5)};
      4'b0_0_10: width_o = '{ras: CNT_W'(13), cas: CNT_W'(6)};
      4'b0_0_11: width_o = '{ras: CNT_W'(16), cas: CNT_W'(7)};
      4'b0_1_00: width_o = '{ras: CNT_W'(9),  cas: CNT_W'(3)};
      4'b0_1_01: width_o = '{ras: CNT_W'(9),  cas: CNT_W'(3)};
      4'b0_1_10: width_o = '{ras: CNT_W'(11), cas: CNT_W'(4)};
      4'b0_1_11: width_o = '{ras: CNT_W'(14), cas: CNT_W'(5)};
      4'b1_0_00: width_o = '{ras: CNT_W'(12), cas: CNT_W'(6)};
      4'b1_0_01: width_o = '{ras: CNT_W'(12), cas: CNT_W'(6)};
      4'b1_0_10: width_o = '{ras: CNT_W'(15), cas: CNT_W'(6)};
      4'b1_0_11: width_o = '{ras: CNT_W'(18), cas: CNT_W'(9)};
      4'b1_1_00: width_o = '{ras: CNT_W'(9),  cas: CNT_W'(3)};
      4'b1_1_01: width_o = '{ras: CNT_W'(9),  cas: CNT_W'(3)};
      4'b1_1_10: width_o = '{ras: CNT_W'(12), cas: CNT_W'(6)};
      4'b1_1_11: width_o = '{ras: CNT_W'(15), cas: CNT_W'(6)};
      default:   width_o = '0;
    endcase
  end
endmodule

// File: rtl/dst_seq.sv
module dst_seq
  import dst_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   align_gclk_i,
  input  logic   sync_t2_i,
  input  width_t width_i,
  output logic   accept_o,
  output logic   ras_no,
  output logic   cas_no,
  output logic   busy_o,
  output logic   done_o
);
  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d;
  logic             last;

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign last     = (cnt_q == width_i.ras - CNT_W'(1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        cnt_d = '0;
        st_d  = (align_gclk_i && !sync_t2_i) ? ST_SYNC : ST_RAS;
      end
      ST_SYNC: if (sync_t2_i) begin
        cnt_d = '0;
        st_d  = ST_RAS;
      end
      ST_RAS: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_o <= done_d;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign ras_no = (st_q != ST_RAS);
  // column strobe occupies the tail of the row window
  assign cas_no = !((st_q == ST_RAS) && (cnt_q >= width_i.ras - width_i.cas));

  p_cas_within_ras_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no);
  p_cas_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |-> $rose(cas_no));
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_ras_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ras_no && !busy_o && $rose(ras_no)));
  p_wait_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SYNC && !sync_t2_i) |=> (ras_no && busy_o));
endmodule

// File: rtl/dram_strobe_timer.sv
module dram_strobe_timer
  import dst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       is_write_i,
  input  logic       align_gclk_i,
  input  logic [2:0] speed_sel_i,
  input  logic       sync_t2_i,
  output logic       ras_no,
  output logic       cas_no,
  output logic       busy_o,
  output logic       done_o
);
  logic [2:0] sel_q;
  logic       wr_q;
  logic       al_q;
  logic       accept;
  width_t     width;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      wr_q  <= 1'b0;
      al_q  <= 1'b0;
    end else if (accept) begin
      sel_q <= speed_sel_i;
      wr_q  <= is_write_i;
      al_q  <= align_gclk_i;
    end
  end

  dst_width_lut u_lut (
    .speed_sel_i  (sel_q),
    .is_write_i   (wr_q),
    .align_gclk_i (al_q),
    .width_o      (width)
  );

  dst_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .align_gclk_i (align_gclk_i),
    .sync_t2_i    (sync_t2_i),
    .width_i      (width),
    .accept_o     (accept),
    .ras_no       (ras_no),
    .cas_no       (cas_no),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  p_hold_cfg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable({sel_q, wr_q, al_q}));
  p_gclk_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && al_q) |-> $past(sync_t2_i));
endmodule

// File: tb/sim_dram_strobe_timer.sv
module sim_dram_strobe_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_wr = 1'b0, align = 1'b0, sync_t2 = 1'b0;
  logic [2:0] speed = '0;
  logic ras_n, cas_n, busy, done;
  logic sync_run = 1'b0;
  int   ph = 0;
  int   n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!sync_run) begin
      ph <= 0; sync_t2 <= 1'b0;
    end else begin
      ph <= (ph + 1) % 3; sync_t2 <= (ph == 1);
    end
  end

  dram_strobe_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_write_i(is_wr),
    .align_gclk_i(align), .speed_sel_i(speed), .sync_t2_i(sync_t2),
    .ras_no(ras_n), .cas_no(cas_n), .busy_o(busy), .done_o(done));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ras(input int code, input bit wr, input bit al);
    int r = (code > 3) ? 3 : code;
    int t[16] = '{10,11,13,16, 9,9,11,14, 12,12,15,18, 9,9,12,15};
    return t[al*8 + wr*4 + r];
  endfunction

  function automatic int exp_cas(input int code, input bit wr, input bit al);
    int r = (code > 3) ? 3 : code;
    int t[16] = '{4,5,6,7, 3,3,4,5, 6,6,6,9, 3,3,6,6};
    return t[al*8 + wr*4 + r];
  endfunction

  // one access; all driving and sampling at negedge + 1
  task automatic run_one(input int code, input bit wr, input bit al,
                         input bit scramble, input bit poke, input int hold,
                         output int waitc, output int rasc, output int casc,
                         output int casfirst, output int doneidx, output int donecnt,
                         output bit sync_ok, output bit overlap_ok);
    bit seen = 0, prev_sync, poked = 0;
    waitc = 0; rasc = 0; casc = 0; casfirst = -1; doneidx = -1; donecnt = 0;
    sync_ok = 0; overlap_ok = 1;
    @(negedge clk); #1;
    speed = code[2:0]; is_wr = wr; align = al; start = 1'b1;
    prev_sync = sync_t2;
    @(negedge clk); #1;
    start = 1'b0;
    if (scramble) begin speed = ~code[2:0]; is_wr = ~wr; align = ~al; end
    for (int i = 0; i < 60; i++) begin
      if (i == hold) sync_run = 1'b1;
      if (poked) begin start = 1'b0; poked = 0; end
      if (!seen && ras_n && busy) waitc++;
      if (!ras_n) begin
        if (!seen) begin seen = 1; sync_ok = prev_sync; end
        rasc++;
      end
      if (!cas_n) begin
        if (casfirst < 0) casfirst = rasc - 1;
        casc++;
        if (ras_n) overlap_ok = 0;
      end
      if (done) begin
        donecnt++;
        if (doneidx < 0) doneidx = busy ? -2 : rasc;
      end
      if (poke && rasc == 2 && !ras_n) begin
        start = 1'b1; speed = 3'd0; is_wr = 1'b1; align = 1'b0; poked = 1;
      end
      prev_sync = sync_t2;
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 ras_no in reset", ras_n, 1);
    chk("R1 cas_no in reset", cas_n, 1);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 ras_no after reset", ras_n, 1);
    chk("R1 busy after reset", busy, 0);
  endtask

  task automatic t_table(input bit wr, input bit al, input int lo, input int hi, input string req);
    int w, r, c, cf, di, dc; bit so, ov;
    for (int code = lo; code <= hi; code++) begin
      run_one(code, wr, al, 0, 0, 0, w, r, c, cf, di, dc, so, ov);
      chk({req, " ras width"}, r, exp_ras(code, wr, al));
      chk({req, " cas width"}, c, exp_cas(code, wr, al));
      chk("R6 cas tail start", cf, exp_ras(code, wr, al) - exp_cas(code, wr, al));
      chk("R6 cas only inside ras", ov, 1);
      chk("R10 done index", di, exp_ras(code, wr, al));
      chk("R10 done count", dc, 1);
      if (al) chk("R7 ras falls on sync_t2", so, 1);
    end
  endtask

  task automatic t_wait_sync;
    int w, r, c, cf, di, dc; bit so, ov;
    sync_run = 1'b0;
    run_one(1, 0, 1, 0, 0, 7, w, r, c, cf, di, dc, so, ov);
    chk("R7 busy while waiting", (w >= 7) ? 1 : 0, 1);
    chk("R7 ras falls on sync_t2", so, 1);
    chk("R7 ras width after wait", r, 12);
  endtask

  task automatic t_ref_no_sync;
    int w, r, c, cf, di, dc; bit so, ov;
    sync_run = 1'b0;
    run_one(2, 1, 0, 0, 0, 100, w, r, c, cf, di, dc, so, ov);
    chk("R8 no wait without sync_t2", w, 0);
    chk("R8 ras width", r, 11);
    sync_run = 1'b1;
  endtask

  task automatic t_capture;
    int w, r, c, cf, di, dc; bit so, ov;
    run_one(3, 0, 0, 1, 0, 0, w, r, c, cf, di, dc, so, ov);
    chk("R9 ras width held", r, 16);
    chk("R9 cas width held", c, 7);
    chk("R9 no wait from later align", w, 0);
  endtask

  task automatic t_busy_start;
    int w, r, c, cf, di, dc; bit so, ov;
    run_one(2, 0, 0, 0, 1, 0, w, r, c, cf, di, dc, so, ov);
    chk("R11 ras width unchanged", r, 13);
    chk("R11 single done", dc, 1);
    chk("R11 idle afterwards", busy, 0);
  endtask

  initial begin
    bit timed_out = 0;
    fork
      begin
        t_reset();
        sync_run = 1'b1;
        t_table(0, 0, 0, 3, "R2");
        t_table(1, 0, 0, 3, "R3");
        t_table(0, 1, 0, 3, "R4");
        t_table(1, 1, 0, 3, "R4");
        t_table(0, 0, 4, 7, "R5");
        t_table(1, 1, 4, 7, "R5");
        t_wait_sync();
        t_ref_no_sync();
        t_capture();
        t_busy_start();
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule